// File: doc/BRIEF.md
# Smart-card asynchronous byte receiver

This block receives character frames from a single serial line of a smart-card interface. A frame starts with a low start bit. Eight data bits follow, least significant bit first, then one parity bit and then one or two high stop bits. The bit period in clock cycles is set at run time by the `bit_cycles` input. The receiver samples each bit once, at the middle of its period. The serial line passes through a two-stage synchronizer, and a frame begins on a falling edge of the synchronized line.

The received byte is held on `rx_byte`, together with three sticky flags: byte ready, overrun and frame error. A host clears all three flags with an acknowledge pulse. A pending-start status shows that a falling edge is being verified as a real start bit, so a short glitch is dropped without any effect. An active-reception status covers the confirmed frame, and a one-cycle end-of-reception strobe marks its close.

Top module: `sc_byte_rx`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is driven to 0 after that edge, and it stays 0 until a frame arrives.
- R2: The bit period P is `bit_cycles`+1 clock cycles. A frame with good parity loads `rx_byte` (bit 0 is the first bit after the start bit) and sets `byte_ready`. With the default `PAR_ODD`=0 the parity bit equals the XOR of the eight data bits. While `byte_ready` is high and `flag_ack` is low, `rx_byte` does not change.
- R3: `byte_ready` rises no earlier than 9.5·P−1 and no later than 9.5·P+P/4+1 clock edges after the edge that first samples the start bit low.
- R4: A low pulse on the line shorter than P/2−2 cycles raises `start_pending` and then drops it. It never raises `rx_busy` and sets no flag, and the next real frame is received normally.
- R5: `start_pending` and `rx_busy` are never high together. `rx_busy` rises only directly after `start_pending`.
- R6: A parity mismatch sets `frame_err`, leaves `byte_ready` low and leaves `rx_byte` unchanged.
- R7: When `two_stop` is 0 there is one stop bit, and when it is 1 there are two. A stop bit sampled low sets `frame_err`. With two stop bits, `rx_busy` falls between 12·P−P/4 and 12·P edges after the start edge.
- R8: A new start edge at or before the nominal frame time (11·P, or 12·P with two stop bits) minus P/4 minus 2 cycles sets `frame_err`, and that frame is still received. A start edge at or after the nominal time minus P/8 raises no error.
- R9: If a good frame completes while `byte_ready` is high and `flag_ack` is low, `overrun_err` is set and `rx_byte` keeps the earlier byte.
- R10: A one-cycle `flag_ack` pulse clears `byte_ready`, `overrun_err` and `frame_err` by the next cycle. While `flag_ack` is held high, a new ready or frame-error event still raises its flag for at least one cycle.
- R11: With one stop bit, `rx_busy` falls between 11·P−P/4 and 11·P edges after the start edge. It goes low between back-to-back frames. `rx_done` is high for exactly the first cycle after each fall of `rx_busy`, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Serial line from the card, idle high, asynchronous |
| bit_cycles | input | 13 | Bit period minus one, in clock cycles |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| flag_ack | input | 1 | Clears the ready, overrun and frame-error flags |
| rx_byte | output | 8 | Last byte accepted |
| byte_ready | output | 1 | A new byte is waiting |
| overrun_err | output | 1 | A byte completed while the previous one was unread |
| frame_err | output | 1 | Bad parity, low stop bit or early start bit |
| start_pending | output | 1 | Falling edge seen, start bit not yet confirmed |
| rx_busy | output | 1 | Confirmed frame in progress |
| rx_done | output | 1 | One-cycle strobe after the end of a reception |

## Verification
The bench places start edges on both sides of the early-start limit. A receiver that measures the frame wrongly would either flag a legal back-to-back frame or accept a truncated stop bit. It also sends glitches just short of half a bit, which a receiver that confirms too early would treat as a frame, raising `rx_busy` and later a flag. Frames arrive while the previous byte is still unread, so a design that overwrites the held byte or misses the overrun shows it at once. Acknowledge held high during a completion catches flag logic in which the clear wins over the set, because then no flag ever appears.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    localparam int unsigned SC_BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP1,
        RX_STOP2,
        RX_TAIL
    } rx_state_e;

    typedef struct packed {
        logic                 good;
        logic                 fault;
        logic [SC_BYTE_W-1:0] data;
    } rx_event_t;

    function automatic logic parity_of(input logic [SC_BYTE_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic logic state_busy(input rx_state_e s);
        return (s == RX_DATA) || (s == RX_PAR) || (s == RX_STOP1) ||
               (s == RX_STOP2) || (s == RX_TAIL);
    endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign line_s = chain_q[STAGES-1];
    assign fall   = prev_q & ~line_s;
endmodule

// File: rtl/sc_rx_tick.sv
module sc_rx_tick #(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (load)  cnt_q <= load_val;
        else if (!tick) cnt_q <= cnt_q - W'(1);
    end
endmodule

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
    import sc_rx_pkg::*;
#(
    parameter int unsigned CPB_W   = 13,
    parameter logic        PAR_ODD = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_s,
    input  logic             fall,
    input  logic [CPB_W-1:0] bit_cycles,
    input  logic             two_stop,
    output rx_event_t        ev,
    output logic             start_pending,
    output logic             rx_busy,
    output logic             rx_done
);
    localparam int unsigned IDX_W    = $clog2(SC_BYTE_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SC_BYTE_W - 1);

    rx_state_e              state_q, state_d;
    logic [IDX_W-1:0]       idx_q, idx_d;
    logic [SC_BYTE_W-1:0]   sh_q, sh_d;
    logic                   done_q;
    logic                   load, tick;
    logic [CPB_W-1:0]       load_val, half, quarter;

    assign half    = bit_cycles >> 1;
    assign quarter = bit_cycles >> 2;

    sc_rx_tick #(.W(CPB_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .tick     (tick)
    );

    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        sh_d     = sh_q;
        load     = 1'b0;
        load_val = bit_cycles;
        ev       = '0;
        ev.data  = sh_q;
        unique case (state_q)
            RX_IDLE: begin
                if (fall) begin
                    state_d  = RX_START;
                    load     = 1'b1;
                    load_val = half;
                end
            end
            RX_START: begin
                if (line_s) begin
                    state_d = RX_IDLE;
                end else if (tick) begin
                    state_d = RX_DATA;
                    load    = 1'b1;
                    idx_d   = '0;
                end
            end
            RX_DATA: begin
                if (tick) begin
                    sh_d = {line_s, sh_q[SC_BYTE_W-1:1]};
                    load = 1'b1;
                    if (idx_q == IDX_LAST) state_d = RX_PAR;
                    else                   idx_d   = idx_q + IDX_W'(1);
                end
            end
            RX_PAR: begin
                if (tick) begin
                    load    = 1'b1;
                    state_d = RX_STOP1;
                    if (line_s == parity_of(sh_q, PAR_ODD)) ev.good  = 1'b1;
                    else                                    ev.fault = 1'b1;
                end
            end
            RX_STOP1: begin
                if (tick) begin
                    if (!line_s) begin
                        ev.fault = 1'b1;
                        state_d  = RX_IDLE;
                    end else if (two_stop) begin
                        state_d = RX_STOP2;
                        load    = 1'b1;
                    end else begin
                        state_d  = RX_TAIL;
                        load     = 1'b1;
                        load_val = quarter;
                    end
                end
            end
            RX_STOP2: begin
                if (tick) begin
                    if (!line_s) begin
                        ev.fault = 1'b1;
                        state_d  = RX_IDLE;
                    end else begin
                        state_d  = RX_TAIL;
                        load     = 1'b1;
                        load_val = quarter;
                    end
                end
            end
            RX_TAIL: begin
                if (fall) begin
                    ev.fault = 1'b1;
                    state_d  = RX_START;
                    load     = 1'b1;
                    load_val = half;
                end else if (tick) begin
                    state_d = RX_IDLE;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
            idx_q   <= '0;
            sh_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
            done_q  <= state_busy(state_q) && !state_busy(state_d);
        end
    end

    assign start_pending = (state_q == RX_START);
    assign rx_busy       = state_busy(state_q);
    assign rx_done       = done_q;

    // R4
    glitch_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (start_pending && line_s) |=> (!start_pending && !rx_busy));

    // R5
    busy_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_busy) |-> $past(start_pending));

    // R11
    done_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> $fell(rx_busy));
endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags
    import sc_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  rx_event_t            ev,
    input  logic                 flag_ack,
    output logic [SC_BYTE_W-1:0] rx_byte,
    output logic                 byte_ready,
    output logic                 overrun_err,
    output logic                 frame_err
);
    logic ready_q, ovr_q, ferr_q;
    logic [SC_BYTE_W-1:0] byte_q;
    logic load;

    assign load = ev.good && (!ready_q || flag_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            ovr_q   <= 1'b0;
            ferr_q  <= 1'b0;
            byte_q  <= '0;
        end else begin
            ready_q <= load | (ready_q & ~flag_ack);
            ovr_q   <= (ev.good & ready_q & ~flag_ack) | (ovr_q & ~flag_ack);
            ferr_q  <= ev.fault | (ferr_q & ~flag_ack);
            if (load) byte_q <= ev.data;
        end
    end

    assign rx_byte     = byte_q;
    assign byte_ready  = ready_q;
    assign overrun_err = ovr_q;
    assign frame_err   = ferr_q;

    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_ack && !ev.good && !ev.fault) |=> (!byte_ready && !overrun_err && !frame_err));

    // R10
    set_under_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ev.good |=> byte_ready);

    // R6
    fault_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ev.fault |=> frame_err);

    // R9
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.good && byte_ready && !flag_ack) |=> (overrun_err && $stable(rx_byte)));

    // R2
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_ready && !flag_ack) |=> $stable(rx_byte));
endmodule

// File: rtl/sc_byte_rx.sv
module sc_byte_rx
    import sc_rx_pkg::*;
#(
    parameter int unsigned CPB_W       = 13,
    parameter logic        PAR_ODD     = 1'b0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_line,
    input  logic [CPB_W-1:0]     bit_cycles,
    input  logic                 two_stop,
    input  logic                 flag_ack,
    output logic [SC_BYTE_W-1:0] rx_byte,
    output logic                 byte_ready,
    output logic                 overrun_err,
    output logic                 frame_err,
    output logic                 start_pending,
    output logic                 rx_busy,
    output logic                 rx_done
);
    logic      line_s, fall;
    rx_event_t ev;

    sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (rx_line),
        .line_s  (line_s),
        .fall    (fall)
    );

    sc_rx_frame #(.CPB_W(CPB_W), .PAR_ODD(PAR_ODD)) u_frame (
        .clk           (clk),
        .rst           (rst),
        .line_s        (line_s),
        .fall          (fall),
        .bit_cycles    (bit_cycles),
        .two_stop      (two_stop),
        .ev            (ev),
        .start_pending (start_pending),
        .rx_busy       (rx_busy),
        .rx_done       (rx_done)
    );

    sc_rx_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .flag_ack    (flag_ack),
        .rx_byte     (rx_byte),
        .byte_ready  (byte_ready),
        .overrun_err (overrun_err),
        .frame_err   (frame_err)
    );

    // R5
    excl_status_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_pending && rx_busy));
endmodule

// File: tb/sim_sc_byte_rx.sv
module sim_sc_byte_rx;
    localparam int P = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic [12:0] bit_cycles = 13'(P - 1);
    logic        two_stop = 1'b0;
    logic        flag_ack = 1'b0;
    logic [7:0]  rx_byte;
    logic        byte_ready, overrun_err, frame_err, start_pending, rx_busy, rx_done;

    always #5 clk = ~clk;

    sc_byte_rx u0 (
        .clk (clk), .rst (rst), .rx_line (rx_line), .bit_cycles (bit_cycles),
        .two_stop (two_stop), .flag_ack (flag_ack), .rx_byte (rx_byte),
        .byte_ready (byte_ready), .overrun_err (overrun_err), .frame_err (frame_err),
        .start_pending (start_pending), .rx_busy (rx_busy), .rx_done (rx_done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // port monitor, sampled on the falling edge
    int   ready_rise = -1, frame_rise = -1, busy_fall = -1;
    int   pend_last = -1, busy_last = -1, busy_falls = 0;
    int   excl_err = 0, done_err = 0;
    logic m_ready = 1'b0, m_frame = 1'b0, m_busy = 1'b0;

    always @(negedge clk) begin
        if (byte_ready && !m_ready) ready_rise = cyc;
        if (frame_err && !m_frame)  frame_rise = cyc;
        if (start_pending) pend_last = cyc;
        if (rx_busy)       busy_last = cyc;
        if (start_pending && rx_busy) excl_err++;
        if (m_busy && !rx_busy) begin
            busy_fall = cyc;
            busy_falls++;
            if (!rx_done) done_err++;
        end else if (rx_done) begin
            done_err++;
        end
        m_ready = byte_ready;
        m_frame = frame_err;
        m_busy  = rx_busy;
    end

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack_pulse();
        flag_ack = 1'b1;
        @(negedge clk);
        flag_ack = 1'b0;
    endtask

    // stop_bad: 0 none, 1 first stop low, 2 second stop low
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input int stop_bad,
                              input int stop_len, output int t0);
        t0 = cyc + 1;
        rx_line = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            repeat (P) @(negedge clk);
        end
        rx_line = (^d) ^ bad_par;
        repeat (P) @(negedge clk);
        if (two_stop) begin
            rx_line = (stop_bad == 1) ? 1'b0 : 1'b1;
            repeat (P) @(negedge clk);
            rx_line = (stop_bad == 2) ? 1'b0 : 1'b1;
            repeat (stop_len) @(negedge clk);
        end else begin
            rx_line = (stop_bad == 1) ? 1'b0 : 1'b1;
            repeat (stop_len) @(negedge clk);
        end
        rx_line = 1'b1;
    endtask

    // {corrupt parity, data}
    localparam logic [8:0] VEC [6] = '{9'h055, 9'h0A3, 9'h13C, 9'h000, 9'h1FF, 9'h081};

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int t0, t1, tg, nb;
        logic [7:0] last_good;

        do_reset();
        // R1 reset state
        chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
        chk({byte_ready, overrun_err, frame_err} == 3'b000, "R1 flags",
            {byte_ready, overrun_err, frame_err}, 0);
        chk({start_pending, rx_busy, rx_done} == 3'b000, "R1 status",
            {start_pending, rx_busy, rx_done}, 0);

        // R4 glitch shorter than half a bit
        tg = cyc + 1;
        rx_line = 1'b0;
        repeat (5) @(negedge clk);
        rx_line = 1'b1;
        repeat (3 * P) @(negedge clk);
        chk(pend_last >= tg, "R4 pending seen", pend_last, tg);
        chk(busy_last < tg, "R4 busy never", busy_last, -1);
        chk({byte_ready, overrun_err, frame_err} == 3'b000, "R4 no flag",
            {byte_ready, overrun_err, frame_err}, 0);
        send_frame(8'hC6, 1'b0, 0, P, t0);
        repeat (4) @(negedge clk);
        chk(byte_ready && rx_byte == 8'hC6, "R4 recovery byte", rx_byte, 8'hC6);
        ack_pulse();
        last_good = 8'hC6;

        // table of frames
        foreach (VEC[k]) begin
            send_frame(VEC[k][7:0], VEC[k][8], 0, P, t0);
            repeat (4) @(negedge clk);
            if (VEC[k][8]) begin
                chk(frame_err == 1'b1, "R6 frame_err", frame_err, 1);
                chk(byte_ready == 1'b0, "R6 no ready", byte_ready, 0);
                chk(rx_byte == last_good, "R6 byte kept", rx_byte, last_good);
            end else begin
                chk(byte_ready == 1'b1, "R2 ready", byte_ready, 1);
                chk(rx_byte == VEC[k][7:0], "R2 byte", rx_byte, VEC[k][7:0]);
                chk(frame_err == 1'b0, "R2 no frame_err", frame_err, 0);
                chk(ready_rise - t0 >= 9 * P + P / 2 - 1 &&
                    ready_rise - t0 <= 9 * P + P / 2 + P / 4 + 1,
                    "R3 ready time", ready_rise - t0, 9 * P + P / 2);
                chk(busy_fall - t0 >= 11 * P - P / 4 && busy_fall - t0 <= 11 * P,
                    "R11 busy fall", busy_fall - t0, 11 * P);
                last_good = VEC[k][7:0];
            end
            ack_pulse();
            chk({byte_ready, overrun_err, frame_err} == 3'b000, "R10 ack clears",
                {byte_ready, overrun_err, frame_err}, 0);
        end

        // R8 accepted start inside tolerance, R9 overrun
        do_reset();
        nb = busy_falls;
        send_frame(8'h5A, 1'b0, 0, P - P / 8, t0);
        send_frame(8'hE1, 1'b0, 0, P, t1);
        repeat (4) @(negedge clk);
        chk(frame_err == 1'b0, "R8 tolerated start", frame_err, 0);
        chk(overrun_err == 1'b1, "R9 overrun", overrun_err, 1);
        chk(rx_byte == 8'h5A, "R9 byte kept", rx_byte, 8'h5A);
        chk(byte_ready == 1'b1, "R9 ready kept", byte_ready, 1);
        chk(busy_falls - nb == 2, "R11 busy gap", busy_falls - nb, 2);
        ack_pulse();
        chk({byte_ready, overrun_err, frame_err} == 3'b000, "R10 ack clears overrun",
            {byte_ready, overrun_err, frame_err}, 0);

        // R8 early start
        do_reset();
        send_frame(8'h33, 1'b0, 0, P / 2 + 2, t0);
        send_frame(8'h44, 1'b0, 0, P, t1);
        repeat (4) @(negedge clk);
        chk(frame_err == 1'b1, "R8 early start", frame_err, 1);
        ack_pulse();

        // R7 stop bits
        do_reset();
        send_frame(8'h96, 1'b0, 1, P, t0);
        repeat (4) @(negedge clk);
        chk(frame_err == 1'b1, "R7 low stop", frame_err, 1);
        ack_pulse();
        two_stop = 1'b1;
        repeat (2) @(negedge clk);
        send_frame(8'h69, 1'b0, 0, P, t0);
        repeat (4) @(negedge clk);
        chk(byte_ready && rx_byte == 8'h69, "R7 two stop byte", rx_byte, 8'h69);
        chk(frame_err == 1'b0, "R7 two stop ok", frame_err, 0);
        chk(busy_fall - t0 >= 12 * P - P / 4 && busy_fall - t0 <= 12 * P,
            "R7 two stop busy fall", busy_fall - t0, 12 * P);
        ack_pulse();
        send_frame(8'h0F, 1'b0, 2, P, t0);
        repeat (4) @(negedge clk);
        chk(frame_err == 1'b1, "R7 second stop low", frame_err, 1);
        ack_pulse();
        two_stop = 1'b0;

        // R10 acknowledge held high
        do_reset();
        flag_ack = 1'b1;
        send_frame(8'hA5, 1'b0, 0, P, t0);
        repeat (4) @(negedge clk);
        chk(ready_rise >= t0, "R10 ready under held ack", ready_rise, t0);
        chk(byte_ready == 1'b0, "R10 held ack clears", byte_ready, 0);
        chk(rx_byte == 8'hA5, "R10 byte under held ack", rx_byte, 8'hA5);
        send_frame(8'h5A, 1'b1, 0, P, t0);
        repeat (4) @(negedge clk);
        chk(frame_rise >= t0, "R10 frame_err under held ack", frame_rise, t0);
        chk(frame_err == 1'b0, "R10 frame_err cleared", frame_err, 0);
        flag_ack = 1'b0;

        chk(excl_err == 0, "R5 exclusive status", excl_err, 0);
        chk(done_err == 0, "R11 done strobe", done_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule